// File: doc/BRIEF.md
# Complementary PWM Generator with Dead Time

This block drives a high-side and a low-side switch from one pulse-width setting. Each period has a high-side pulse and then a low-side pulse, with a programmable gap of dead time between them. The two outputs are never active together, so the block suits half-bridge and H-bridge power stages.

Three configuration inputs set the timing: a 10-bit period, a 10-bit duty value and a 4-bit dead-time value. All timing runs on a slow tick. The tick is a one-cycle clock enable made by an internal prescaler that divides the system clock by a fixed parameter. Period, duty and dead-time down-counters load together at the start of each period and hold once they reach zero. A new setting therefore changes the waveform only from the next period boundary.

Top module: `pwm_dt`

## Requirements
- R1: With duty D no greater than period setting P, every period lasts P+1 ticks and the high-side output is 1 during the first D ticks of it.
- R2: With D greater than P, the high-side output stays 1 for the whole period.
- R3: With D equal to 0, the high-side output stays 0 for the whole period. The low-side output still waits Z ticks, where Z is the dead-time value, before it turns on.
- R4: The low-side output turns on Z ticks after the high-side output turns off. With Z equal to 0 it turns on in the same cycle.
- R5: The low-side output turns off once the period counter has come down to Z. It stays off for the last Z+1 ticks of each period.
- R6: The high-side and low-side outputs are never 1 in the same cycle.
- R7: Period, duty and dead-time inputs are sampled only on the tick that starts a period. Changes made in the middle of a period leave the rest of that period unchanged.
- R8: The counters advance only on the tick. The tick is one system-clock cycle long and repeats every TICK_DIV clocks, counted from reset release. The outputs are registered and change one clock after the tick edge, then stay stable until the next one.
- R9: While rst_ni is 0, both outputs are 0. They stay 0 until the first tick after release, and that tick loads all counters from the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PER_W (10) | Period setting P; one period lasts P+1 ticks |
| duty_i | input | PER_W (10) | High-side on time D, in ticks |
| dead_i | input | DT_W (4) | Dead time Z, in ticks |
| pwm_hi_o | output | 1 | High-side drive |
| pwm_lo_o | output | 1 | Low-side drive, complementary with dead time |

## Verification
The waveform is tried with a mid-range duty and a nonzero dead time, with a duty above the period, with zero duty, with zero dead time and with a zero period. Each pattern puts the edges of the high-side and low-side outputs in a different place: clean pulses, a pinned-high output, a high side that never turns on, edges that touch, and one-tick periods. A setting changed part-way through a period shows whether the old values are kept until the reload. The outputs are compared on every system clock, not only on ticks, so a tick that arrives early, arrives late or lasts too long shows up as a wrong edge. A reset in the middle of a run checks that both outputs are forced low and that the first tick reloads the counters.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int unsigned PWM_PER_W_DEF = 10;
  localparam int unsigned PWM_DT_W_DEF  = 4;
  localparam int unsigned PWM_DIV_DEF   = 12;
endpackage

// File: rtl/pwm_dt_prescale.sv
module pwm_dt_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      assign tick_o = (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_dt_cnt.sv
module pwm_dt_cnt #(
  parameter int unsigned PER_W = 10,
  parameter int unsigned DT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] duty_o,
  output logic [DT_W-1:0]  dead_o,
  output logic [DT_W-1:0]  dead_sh_o
);
  logic [PER_W-1:0] per_q, duty_q;
  logic [DT_W-1:0]  dead_q, dead_sh_q;
  logic             reload;

  assign reload = (per_q == '0);

  // zero-reset makes the first tick a reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q     <= '0;
      duty_q    <= '0;
      dead_q    <= '0;
      dead_sh_q <= '0;
    end else if (tick_i) begin
      if (reload) begin
        per_q     <= period_i;
        duty_q    <= duty_i;
        dead_q    <= dead_i;
        dead_sh_q <= dead_i;
      end else begin
        per_q <= per_q - 1'b1;
        // dead-time count starts only once duty has expired
        if (duty_q != '0)      duty_q <= duty_q - 1'b1;
        else if (dead_q != '0) dead_q <= dead_q - 1'b1;
      end
    end
  end

  assign per_o     = per_q;
  assign duty_o    = duty_q;
  assign dead_o    = dead_q;
  assign dead_sh_o = dead_sh_q;
endmodule

// File: rtl/pwm_dt_out.sv
module pwm_dt_out #(
  parameter int unsigned PER_W = 10,
  parameter int unsigned DT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic [DT_W-1:0]  dead_sh_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic hi_d, lo_d, hi_q, lo_q;

  assign hi_d = (duty_i != '0);
  assign lo_d = (duty_i == '0) && (dead_i == '0) && (per_i > PER_W'(dead_sh_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/pwm_dt.sv
module pwm_dt
  import pwm_dt_pkg::*;
#(
  parameter int unsigned PER_W    = PWM_PER_W_DEF,
  parameter int unsigned DT_W     = PWM_DT_W_DEF,
  parameter int unsigned TICK_DIV = PWM_DIV_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             pwm_hi_o,
  output logic             pwm_lo_o
);
  logic             tick;
  logic [PER_W-1:0] per_q, duty_q;
  logic [DT_W-1:0]  dead_q, dead_sh_q;

  pwm_dt_prescale #(.DIV(TICK_DIV)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  pwm_dt_cnt #(.PER_W(PER_W), .DT_W(DT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .period_i  (period_i),
    .duty_i    (duty_i),
    .dead_i    (dead_i),
    .per_o     (per_q),
    .duty_o    (duty_q),
    .dead_o    (dead_q),
    .dead_sh_o (dead_sh_q)
  );

  pwm_dt_out #(.PER_W(PER_W), .DT_W(DT_W)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .per_i     (per_q),
    .duty_i    (duty_q),
    .dead_i    (dead_q),
    .dead_sh_i (dead_sh_q),
    .hi_o      (pwm_hi_o),
    .lo_o      (pwm_lo_o)
  );
endmodule

// File: rtl/pwm_dt_chk.sv
module pwm_dt_chk #(
  parameter int unsigned PER_W    = 10,
  parameter int unsigned DT_W     = 4,
  parameter int unsigned TICK_DIV = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [PER_W-1:0] per_i,
  input logic [PER_W-1:0] duty_i,
  input logic [DT_W-1:0]  dead_i,
  input logic [DT_W-1:0]  dead_sh_i,
  input logic [PER_W-1:0] period_in_i,
  input logic [PER_W-1:0] duty_in_i,
  input logic [DT_W-1:0]  dead_in_i,
  input logic             hi_i,
  input logic             lo_i
);
  generate
    if (TICK_DIV > 1) begin : g_tick
      // R8
      tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i);
    end
  endgenerate

  // R8
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(per_i) && $stable(duty_i) && $stable(dead_i));

  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && per_i == '0) |=> per_i == $past(period_in_i) && duty_i == $past(duty_in_i)
                                && dead_sh_i == $past(dead_in_i));

  // R4
  dead_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && per_i != '0 && duty_i != '0) |=> $stable(dead_i));

  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_i && lo_i));

  // R1
  hi_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_i) |-> $past(duty_i) == '0);

  // R5
  lo_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lo_i) |-> $past(per_i) <= PER_W'($past(dead_sh_i)));
endmodule

bind pwm_dt pwm_dt_chk #(.PER_W(PER_W), .DT_W(DT_W), .TICK_DIV(TICK_DIV)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .per_i       (per_q),
  .duty_i      (duty_q),
  .dead_i      (dead_q),
  .dead_sh_i   (dead_sh_q),
  .period_in_i (period_i),
  .duty_in_i   (duty_i),
  .dead_in_i   (dead_i),
  .hi_i        (pwm_hi_o),
  .lo_i        (pwm_lo_o)
);

// File: tb/test_pwm_dt.sv
module test_pwm_dt;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] period_i = '0;
  logic [9:0] duty_i = '0;
  logic [3:0] dead_i = '0;
  logic       pwm_hi_o, pwm_lo_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state: position t in the period and values latched at reload
  int  t, lat_p, lat_d, lat_z, pend_p, pend_d, pend_z;
  bit  reload_pend, started;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_dt #(.PER_W(10), .DT_W(4), .TICK_DIV(DIV)) i_pwm_dt (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .duty_i(duty_i),
    .dead_i(dead_i), .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o)
  );

  task automatic check(string tag, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic set_cfg(int p, int d, int z);
    period_i = 10'(p);
    duty_i   = 10'(d);
    dead_i   = 4'(z);
  endtask

  function automatic logic exp_hi();
    return started && (t < lat_d);
  endfunction

  function automatic logic exp_lo();
    return started && (t >= lat_d + lat_z) && (t < lat_p - lat_z);
  endfunction

  // one tick interval: advance reference, then compare on every clock (R8)
  task automatic step_slot(string tag);
    if (reload_pend) begin
      lat_p = pend_p; lat_d = pend_d; lat_z = pend_z; t = 0;
    end else t++;
    reload_pend = (t == lat_p);
    started = 1;
    pend_p = period_i; pend_d = duty_i; pend_z = dead_i;
    for (int i = 0; i < DIV; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      check(tag, "hi (R8 timing)", pwm_hi_o, exp_hi());
      check(tag, "lo (R8 timing)", pwm_lo_o, exp_lo());
      check("R6", "overlap", pwm_hi_o & pwm_lo_o, 1'b0);
    end
  endtask

  task automatic run(string tag, int n);
    for (int k = 0; k < n; k++) step_slot(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R9", "hi in reset", pwm_hi_o, 1'b0);
    check("R9", "lo in reset", pwm_lo_o, 1'b0);
    repeat (2) @(negedge clk_i);
    started = 0; reload_pend = 1; t = 0;
    pend_p = period_i; pend_d = duty_i; pend_z = dead_i;
    rst_ni = 1'b1;
    for (int i = 0; i < DIV; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      check("R9", "hi before first tick", pwm_hi_o, 1'b0);
      check("R9", "lo before first tick", pwm_lo_o, 1'b0);
    end
  endtask

  task automatic t_basic();
    set_cfg(9, 4, 2);
    do_reset();
    run("R1/R4/R5", 30);
  endtask

  task automatic t_full();
    set_cfg(7, 12, 1);
    run("R2", 24);
  endtask

  task automatic t_zero_duty();
    set_cfg(8, 0, 3);
    run("R3", 27);
  endtask

  task automatic t_dead_zero();
    set_cfg(6, 3, 0);
    run("R4/R5", 21);
  endtask

  task automatic t_change();
    set_cfg(9, 5, 2);
    run("R7", 14);
    set_cfg(4, 1, 1);
    run("R7", 16);
  endtask

  task automatic t_period_zero();
    set_cfg(0, 1, 0);
    run("R1", 6);
    set_cfg(0, 0, 2);
    run("R3", 6);
  endtask

  task automatic t_reset_mid();
    set_cfg(9, 3, 2);
    run("R9", 7);
    do_reset();
    run("R9", 22);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_basic();
    t_full();
    t_zero_duty();
    t_dead_zero();
    t_change();
    t_period_zero();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule